// File: doc/BRIEF.md
# Corner-Turn Rule Sequencer

Each router in a deterministically routed two-dimensional mesh holds one of its corners, either Northeast or Northwest, as prohibited for both turn directions, so that routes around faults cannot close a deadlock ring. Before the routing tables are built, this sequencer decides at one router whether that prohibition may stay. A global schedule gives each router one check slot in turn, and only one router is the center at any time. During its own slot the router runs a trial wavefront between the two routers at the ends of its active corner, with the turn still prohibited. It watches the flags that come back over the two corner links. If both ends report a flag, the prohibition is kept and the router locks itself as fixed. If either end stays silent, the corner is opened.

When a corner is opened, the router starts a directed broadcast over a quadrant of the network: East and North for the Northeast corner, North and West for the Northwest corner. Every router that has not been fixed and receives this broadcast swaps its active corner. The new corner starts prohibited and must be checked again in a later slot. Fixed routers keep their rule but still pass the broadcast on, so the whole quadrant is reached. The `rule_done` output tells the schedule when this router has settled.

Top module: `turn_rule_seq`

## Requirements
- R1: After reset the active corner is Northeast (`corner_sel`=0), `turn_block`=2'b01 (bit 0 blocks both Northeast turns, bit 1 blocks both Northwest turns), `fixed`=0, `bc_out`=0 and `rule_done`=0.
- R2: Link bits in `flag_in`, `bc_in` and `bc_out` are ordered North=0, East=1, South=2, West=3. During the router's own slot (`slot_idx`==`my_idx`), flags are collected across every cycle of the slot, including the `slot_end` cycle. At the clock edge where `slot_end` is high, the check passes when a flag arrived on North and also on the active corner's side link (East for Northeast, West for Northwest). On a pass, `fixed` rises, `turn_block` is unchanged and `rule_done` goes high on the following cycle.
- R3: On a failed check, the active corner's `turn_block` bit clears and `bc_out` carries a one-cycle origin broadcast: 4'b0011 for Northeast, 4'b1001 for Northwest.
- R4: Flags received outside the router's own slot, and flags on links other than the two corner links, do not count toward a pass.
- R5: One cycle after a broadcast arrives, it is relayed as follows: arriving from West it goes out East and North; arriving from East it goes out West and North; arriving from South it goes out North only. A broadcast arriving from North is ignored and not relayed.
- R6: A router that is not fixed and receives a broadcast from East, South or West swaps `corner_sel`. The new corner is prohibited, and `rule_done` drops until the router is checked again.
- R7: A fixed router never changes `corner_sel`, `turn_block` or `fixed`, but it still relays broadcasts.
- R8: After a swap, the next own slot checks the new corner's links, and a failure opens that corner and broadcasts in its own directions.
- R9: `rule_done` is low while any `bc_in` or `bc_out` bit is high.
- R10: A router that was checked and has not swapped since is not checked again. A later own slot leaves `turn_block` unchanged and sends no broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_idx | input | IDX_W | This router's index in the check order |
| slot_idx | input | IDX_W | Index of the router whose check slot is running |
| slot_end | input | 1 | High on the last cycle of the current slot |
| flag_in | input | 4 | Trial-routing flags from the neighbours (N,E,S,W) |
| bc_in | input | 4 | Corner-swap broadcast arriving per link |
| turn_block | output | 2 | Turn prohibitions in force: bit 0 Northeast, bit 1 Northwest |
| corner_sel | output | 1 | Active corner: 0 Northeast, 1 Northwest |
| fixed | output | 1 | Rule locked; no further swaps |
| bc_out | output | 4 | Corner-swap broadcast sent per link |
| rule_done | output | 1 | Checked and no broadcast in flight here |

## Verification
The bench builds the block with the default IDX_W=4 and `my_idx`=5. This leaves room for foreign slots, such as index 3, in which flags must be ignored. Slots are one to four cycles long, so flags can arrive early in a slot or only on the `slot_end` cycle. Broadcasts are injected on each of the four links, and repeated swaps are applied before and after a check, to reach the swap, re-check and fixed-lock cases.

// File: rtl/turn_rule_seq.sv
module turn_rule_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] my_idx,
  input  logic [IDX_W-1:0] slot_idx,
  input  logic             slot_end,
  input  logic [3:0]       flag_in,
  input  logic [3:0]       bc_in,
  output logic [1:0]       turn_block,
  output logic             corner_sel,
  output logic             fixed,
  output logic [3:0]       bc_out,
  output logic             rule_done
);
  localparam int LN = 0;
  localparam int LE = 1;
  localparam int LS = 2;
  localparam int LW = 3;

  logic [1:0] opened;
  logic       checked;
  logic [3:0] seen;

  wire       own      = (slot_idx == my_idx);
  wire [3:0] seen_now = seen | flag_in;
  wire       side_ok  = corner_sel ? seen_now[LW] : seen_now[LE];
  wire       pass     = seen_now[LN] & side_ok;
  wire       trial    = own & slot_end & ~checked & ~fixed;
  wire       hit      = bc_in[LE] | bc_in[LS] | bc_in[LW];
  wire       swap     = hit & ~fixed;
  wire [3:0] relay    = {bc_in[LE], 1'b0, bc_in[LW], hit};
  wire [3:0] origin   = (trial & ~pass & ~swap) ? (corner_sel ? 4'b1001 : 4'b0011) : 4'b0000;

  assign turn_block = {corner_sel & ~opened[1], ~corner_sel & ~opened[0]};
  assign rule_done  = checked & ~(|bc_in) & ~(|bc_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
    end else if (!own || slot_end) begin
      seen <= '0;
    end else begin
      seen <= seen_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corner_sel <= 1'b0;
      opened     <= 2'b00;
      checked    <= 1'b0;
      fixed      <= 1'b0;
      bc_out     <= 4'b0000;
    end else begin
      bc_out <= relay | origin;
      if (swap) begin
        corner_sel          <= ~corner_sel;
        opened[~corner_sel] <= 1'b0;
        checked             <= 1'b0;
      end else if (trial) begin
        checked <= 1'b1;
        if (pass) fixed <= 1'b1;
        else opened[corner_sel] <= 1'b1;
      end
    end
  end

  a_r7_fixed_locked: assert property (@(posedge clk) disable iff (!rst_n)
    fixed |=> fixed && $stable(corner_sel) && $stable(turn_block));

  a_r5_west_relay: assert property (@(posedge clk) disable iff (!rst_n)
    bc_in[LW] |=> bc_out[LE] && bc_out[LN]);

  a_r4_quiet_outside_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!own && !hit) |=> $stable(turn_block) && $stable(fixed));

  a_r3_open_broadcasts: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(turn_block[0]) && !corner_sel) |-> (bc_out[LN] && bc_out[LE]));

  a_r2_pass_keeps_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fixed) |-> $stable(turn_block));
endmodule

// File: tb/turn_rule_seq_bench.sv
module turn_rule_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] my_idx = 4'd5;
  logic [3:0] slot_idx;
  logic       slot_end;
  logic [3:0] flag_in;
  logic [3:0] bc_in;
  logic [1:0] turn_block;
  logic       corner_sel;
  logic       fixed;
  logic [3:0] bc_out;
  logic       rule_done;

  int total = 0;
  int bad = 0;

  turn_rule_seq #(.IDX_W(4)) u_turn_rule_seq (
    .clk(clk), .rst_n(rst_n), .my_idx(my_idx), .slot_idx(slot_idx),
    .slot_end(slot_end), .flag_in(flag_in), .bc_in(bc_in),
    .turn_block(turn_block), .corner_sel(corner_sel), .fixed(fixed),
    .bc_out(bc_out), .rule_done(rule_done)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slot_idx = 4'd0; slot_end = 1'b0; flag_in = 4'd0; bc_in = 4'd0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_slot(input logic [3:0] idx, input logic [3:0] f_first,
                          input logic [3:0] f_last, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      slot_idx = idx;
      slot_end = (i == len - 1);
      flag_in  = (i == 0) ? f_first : ((i == len - 1) ? f_last : 4'd0);
    end
    @(negedge clk);
    slot_idx = 4'd0; slot_end = 1'b0; flag_in = 4'd0;
  endtask

  task automatic pulse_bc(input logic [3:0] v);
    @(negedge clk);
    bc_in = v;
    @(negedge clk);
    bc_in = 4'd0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 turn_block", turn_block, 1);
    chk("R1 corner_sel", corner_sel, 0);
    chk("R1 fixed", fixed, 0);
    chk("R1 bc_out", bc_out, 0);
    chk("R1 rule_done", rule_done, 0);
  endtask

  task automatic t_pass();
    do_reset();
    run_slot(4'd5, 4'b0001, 4'b0010, 4);
    chk("R2 fixed", fixed, 1);
    chk("R2 turn_block", turn_block, 1);
    chk("R2 bc_out", bc_out, 0);
    chk("R2 rule_done", rule_done, 1);
  endtask

  task automatic t_fail();
    do_reset();
    run_slot(4'd5, 4'b0001, 4'b0000, 4);
    chk("R3 turn_block", turn_block, 0);
    chk("R3 bc_out", bc_out, 4'b0011);
    chk("R3 fixed", fixed, 0);
    chk("R9 rule_done during bc_out", rule_done, 0);
    @(negedge clk);
    chk("R3 bc_out one cycle", bc_out, 0);
    chk("R9 rule_done after", rule_done, 1);
  endtask

  task automatic t_ignore();
    do_reset();
    run_slot(4'd3, 4'b0011, 4'b0011, 3);
    chk("R4 foreign slot no effect", turn_block, 1);
    chk("R4 foreign slot no fixed", fixed, 0);
    run_slot(4'd5, 4'b0100, 4'b1001, 2);
    chk("R4 wrong links fail", turn_block, 0);
    chk("R4 fail broadcast", bc_out, 4'b0011);
    do_reset();
    run_slot(4'd5, 4'b0011, 4'b0011, 1);
    chk("R2 flags on slot_end cycle count", fixed, 1);
  endtask

  task automatic t_relay();
    do_reset();
    pulse_bc(4'b1000);
    chk("R5 from W", bc_out, 4'b0011);
    chk("R9 rule_done low", rule_done, 0);
    do_reset();
    pulse_bc(4'b0010);
    chk("R5 from E", bc_out, 4'b1001);
    do_reset();
    pulse_bc(4'b0100);
    chk("R5 from S", bc_out, 4'b0001);
    do_reset();
    pulse_bc(4'b0001);
    chk("R5 from N ignored", bc_out, 0);
    chk("R5 from N no swap", corner_sel, 0);
  endtask

  task automatic t_toggle();
    do_reset();
    pulse_bc(4'b0100);
    chk("R6 sel swapped", corner_sel, 1);
    chk("R6 new corner blocked", turn_block, 2);
    chk("R6 rule_done", rule_done, 0);
    run_slot(4'd5, 4'b0001, 4'b1000, 3);
    chk("R8 NW pass fixed", fixed, 1);
    chk("R8 NW kept", turn_block, 2);
    do_reset();
    pulse_bc(4'b1000);
    run_slot(4'd5, 4'b0001, 4'b0010, 3);
    chk("R8 NW fail opens", turn_block, 0);
    chk("R8 NW broadcast", bc_out, 4'b1001);
    do_reset();
    run_slot(4'd5, 4'b0000, 4'b0000, 2);
    pulse_bc(4'b0100);
    chk("R6 after open swap blocked", turn_block, 2);
    chk("R6 after open not done", rule_done, 0);
    pulse_bc(4'b0100);
    chk("R6 swap back re-blocks NE", turn_block, 1);
    chk("R6 swap back sel", corner_sel, 0);
  endtask

  task automatic t_fixed();
    do_reset();
    run_slot(4'd5, 4'b0011, 4'b0000, 2);
    pulse_bc(4'b1000);
    chk("R7 relays", bc_out, 4'b0011);
    chk("R7 sel kept", corner_sel, 0);
    chk("R7 rule kept", turn_block, 1);
    chk("R7 still fixed", fixed, 1);
    @(negedge clk);
    chk("R7 done after bc", rule_done, 1);
  endtask

  task automatic t_once();
    do_reset();
    run_slot(4'd5, 4'b0000, 4'b0000, 2);
    @(negedge clk);
    run_slot(4'd5, 4'b0011, 4'b0011, 2);
    chk("R10 no re-check", turn_block, 0);
    chk("R10 no broadcast", bc_out, 0);
    chk("R10 not fixed", fixed, 0);
    chk("R10 still done", rule_done, 1);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; slot_idx = 4'd0; slot_end = 1'b0; flag_in = 4'd0; bc_in = 4'd0;
    t_reset();
    t_pass();
    t_fail();
    t_ignore();
    t_relay();
    t_toggle();
    t_fixed();
    t_once();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule